// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a single-port synchronous static RAM. It accepts a new read or write command on every clock edge, with no idle cycles needed between reads and writes. Each command's address and controls are registered at its edge. The data for that command crosses the bus two enabled clock edges later. Write data follows the same two-edge schedule as read data, so read and write slots never collide on the shared bus.

A command can load an external address, or it can advance an internal burst counter. The counter steps the two low address bits through a wrapping group of four. Each of the four 9-bit byte lanes has its own write enable. Three select inputs must all be true for the chip to take a command. An active-low clock enable freezes the whole pipeline. The bidirectional bus is split into an input port, an output port and an output-enable. The array depth is set by the address-width parameter.

Top module: `zbt_sram`

## Requirements
- R1: A load cycle (`burstNext`=0) takes a command only if `selA_n`=0, `selB`=1 and `selC_n`=0. If any one of these is false, the cycle is a deselect: it writes nothing, ends any burst, and `dOe` is 0 after the second enabled edge that follows it.
- R2: A selected load with `isRead`=1 at edge N drives the word at `addr` on `dOut`, with `dOe`=1, after enabled edge N+2.
- R3: A selected load with `isRead`=0 at edge N stores the `dIn` value sampled at enabled edge N+2. `dOe` is 0 after that edge.
- R4: Lane i is bits [9i+8:9i]. `laneWrEn_n[i]`=0 on the command cycle writes lane i, and any combination of lanes may be written together. A write with all four enables at 1 changes nothing.
- R5: A cycle with `burstNext`=1 after a load continues the burst, using the read/write type latched at the load. `isRead` and the select inputs are ignored on that cycle. The address is the previous burst address with bits [1:0] incremented modulo 4 and the upper bits unchanged.
- R6: A cycle with `burstNext`=1 when no burst is open (after reset or after a deselect) is a no-op. It neither writes nor drives the bus.
- R7: While `clkEn_n`=1 at an edge, that edge is ignored. `dOut`, `dOe`, the array and all pipeline and burst state keep their values, and the two-edge data delay is stretched by the ignored edges.
- R8: While and after reset, `dOe` is 0 and no command is pending.
- R9: Reads and writes can alternate on consecutive edges. A read issued on the edge right after a write to the same address returns the newly merged data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clkEn_n | input | 1 | Clock enable, active low; 1 suspends the edge |
| selA_n | input | 1 | Chip select, active low |
| selB | input | 1 | Chip select, active high |
| selC_n | input | 1 | Chip select, active low |
| burstNext | input | 1 | 0 loads an external address, 1 advances the burst |
| isRead | input | 1 | 1 read, 0 write; sampled on loads only |
| laneWrEn_n | input | 4 | Per-lane write enables, active low |
| addr | input | ADDR_W | External word address |
| dIn | input | 36 | Write data, sampled two enabled edges after its command |
| dOut | output | 36 | Read data |
| dOe | output | 1 | Output enable; 0 means the bus is high-impedance |

## Verification
The main function is tried under several command patterns. Back-to-back write streams and back-to-back read streams check the plain two-edge timing. Alternating write/read pairs to one address tell a correct ordering apart from a stale read. Partial-lane and no-lane writes show that the mask is captured with the command and not with the data. Burst loads at an address with low bits 3 show the counter wrapping and the latched type ignoring `isRead`. Suspend cycles placed between a command and its data phase tell a frozen pipeline apart from one that keeps counting.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // per-stage command record carried down the pipeline
  typedef struct packed {
    logic             valid;
    logic             isWr;
    logic [LANES-1:0] laneWe;
  } zbt_op_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             stall;
    logic             rdStb;
    logic             wrStb;
    logic [LANES-1:0] laneWe;
  } zbt_strobe_t;
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2,
  parameter int LATENCY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkEn_n,
  input  logic              selA_n,
  input  logic              selB,
  input  logic              selC_n,
  input  logic              burstNext,
  input  logic              isRead,
  input  logic [LANES-1:0]  laneWrEn_n,
  input  logic [ADDR_W-1:0] addr,
  output zbt_strobe_t       strobe,
  output logic [ADDR_W-1:0] opAddr
);
  localparam int LAST = LATENCY - 1;

  logic go;
  logic chipSel;
  assign go      = ~clkEn_n;
  assign chipSel = ~selA_n & selB & ~selC_n;

  logic              burstAct, burstWr;
  logic [ADDR_W-1:0] burstAddr;
  logic              nBurstAct, nBurstWr;
  logic [ADDR_W-1:0] nBurstAddr;
  zbt_op_t           newOp;
  logic [ADDR_W-1:0] newAddr;
  logic [BURST_W-1:0] nextLow;

  assign nextLow = burstAddr[BURST_W-1:0] + BURST_W'(1);

  always_comb begin
    newOp      = '0;
    newAddr    = burstAddr;
    nBurstAct  = burstAct;
    nBurstWr   = burstWr;
    nBurstAddr = burstAddr;
    if (!burstNext) begin
      if (chipSel) begin
        newOp.valid = 1'b1;
        newOp.isWr  = ~isRead;
        newAddr     = addr;
        nBurstAct   = 1'b1;
        nBurstWr    = ~isRead;
        nBurstAddr  = addr;
      end else begin
        nBurstAct = 1'b0;
      end
    end else if (burstAct) begin
      newOp.valid = 1'b1;
      newOp.isWr  = burstWr;
      newAddr     = {burstAddr[ADDR_W-1:BURST_W], nextLow};
      nBurstAddr  = newAddr;
    end
    newOp.laneWe = newOp.isWr ? ~laneWrEn_n : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burstAct  <= 1'b0;
      burstWr   <= 1'b0;
      burstAddr <= '0;
    end else if (go) begin
      burstAct  <= nBurstAct;
      burstWr   <= nBurstWr;
      burstAddr <= nBurstAddr;
    end
  end

  zbt_op_t           stOp   [LATENCY];
  logic [ADDR_W-1:0] stAddr [LATENCY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LATENCY; i++) begin
        stOp[i]   <= '0;
        stAddr[i] <= '0;
      end
    end else if (go) begin
      stOp[0]   <= newOp;
      stAddr[0] <= newAddr;
      for (int i = 1; i < LATENCY; i++) begin
        stOp[i]   <= stOp[i-1];
        stAddr[i] <= stAddr[i-1];
      end
    end
  end

  assign strobe.stall  = ~go;
  assign strobe.rdStb  = stOp[LAST].valid & ~stOp[LAST].isWr;
  assign strobe.wrStb  = stOp[LAST].valid &  stOp[LAST].isWr;
  assign strobe.laneWe = stOp[LAST].laneWe;
  assign opAddr        = stAddr[LAST];

  // R5: advancing wraps the low bits and keeps the upper bits
  p_burst_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && burstNext && burstAct) |=>
      (burstAddr[BURST_W-1:0] == BURST_W'($past(burstAddr[BURST_W-1:0]) + BURST_W'(1))) &&
      (burstAddr[ADDR_W-1:BURST_W] == $past(burstAddr[ADDR_W-1:BURST_W])));

  // R7: an ignored edge leaves burst and pipeline address state alone
  p_freeze_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clkEn_n |=> ($stable(burstAddr) && $stable(opAddr) && $stable(burstAct)));
endmodule

// File: rtl/zbt_datapath.sv
module zbt_datapath
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  zbt_strobe_t       strobe,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [WORD_W-1:0] dIn,
  output logic [WORD_W-1:0] dOut,
  output logic              dOe
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!strobe.stall && strobe.wrStb) begin
      for (int l = 0; l < LANES; l++) begin
        if (strobe.laneWe[l]) mem[opAddr][l*LANE_W +: LANE_W] <= dIn[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dOut <= '0;
      dOe  <= 1'b0;
    end else if (!strobe.stall) begin
      dOe <= strobe.rdStb;
      if (strobe.rdStb) dOut <= mem[opAddr];
    end
  end

  // R7: the bus holds its value across an ignored edge
  p_bus_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stall |=> ($stable(dOut) && $stable(dOe)));
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkEn_n,
  input  logic              selA_n,
  input  logic              selB,
  input  logic              selC_n,
  input  logic              burstNext,
  input  logic              isRead,
  input  logic [LANES-1:0]  laneWrEn_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dIn,
  output logic [WORD_W-1:0] dOut,
  output logic              dOe
);
  localparam int DEPTH = 2 ** ADDR_W;

  zbt_strobe_t       strobe;
  logic [ADDR_W-1:0] opAddr;

  zbt_ctrl #(.ADDR_W(ADDR_W), .BURST_W(2), .LATENCY(2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clkEn_n(clkEn_n),
    .selA_n(selA_n), .selB(selB), .selC_n(selC_n),
    .burstNext(burstNext), .isRead(isRead), .laneWrEn_n(laneWrEn_n),
    .addr(addr), .strobe(strobe), .opAddr(opAddr)
  );

  zbt_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opAddr(opAddr),
    .dIn(dIn), .dOut(dOut), .dOe(dOe)
  );

  logic chkSel;
  assign chkSel = ~selA_n & selB & ~selC_n;

  // R1: a deselect leaves the bus undriven two enabled edges later
  p_deselect_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEn_n && !burstNext && !chkSel) ##1 !clkEn_n ##1 !clkEn_n |=> !dOe);

  // R2: a read load drives the bus two enabled edges later
  p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEn_n && !burstNext && chkSel && isRead) ##1 !clkEn_n ##1 !clkEn_n |=> dOe);

  // R3: a write load keeps the bus undriven in its data slot
  p_write_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEn_n && !burstNext && chkSel && !isRead) ##1 !clkEn_n ##1 !clkEn_n |=> !dOe);
endmodule

// File: tb/zbt_sram_bench.sv
module zbt_sram_bench;
  import zbt_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 8;
  localparam int DEPTH = 2 ** AW;

  logic clk = 1'b0;
  logic rst_n;
  logic clkEn_n, selA_n, selB, selC_n, burstNext, isRead;
  logic [LANES-1:0]  laneWrEn_n;
  logic [AW-1:0]     addr;
  logic [WORD_W-1:0] dIn, dOut;
  logic              dOe;

  zbt_sram #(.ADDR_W(AW)) u_zbt_sram (
    .clk(clk), .rst_n(rst_n), .clkEn_n(clkEn_n), .selA_n(selA_n), .selB(selB),
    .selC_n(selC_n), .burstNext(burstNext), .isRead(isRead), .laneWrEn_n(laneWrEn_n),
    .addr(addr), .dIn(dIn), .dOut(dOut), .dOe(dOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // reference model state, built from the requirements
  logic [WORD_W-1:0] refMem [DEPTH];
  logic              mV [2];
  logic              mW [2];
  logic [AW-1:0]     mA [2];
  logic [LANES-1:0]  mM [2];
  logic              bAct, bWr;
  logic [AW-1:0]     bAddr;
  logic              expOe;
  logic [WORD_W-1:0] expOut;

  function automatic logic [WORD_W-1:0] pat(input logic [7:0] a, input logic [7:0] k);
    return {4'hA, a, k, ~a, a ^ k};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic cen, input logic c1n, input logic c2, input logic c3n,
                      input logic adv, input logic rw, input logic [LANES-1:0] bwn,
                      input logic [AW-1:0] a, input logic [WORD_W-1:0] din, input string tag);
    clkEn_n = cen; selA_n = c1n; selB = c2; selC_n = c3n;
    burstNext = adv; isRead = rw; laneWrEn_n = bwn; addr = a; dIn = din;
    @(posedge clk);
    if (!cen) begin
      if (mV[1] && mW[1])
        for (int l = 0; l < LANES; l++)
          if (mM[1][l]) refMem[mA[1]][l*LANE_W +: LANE_W] = din[l*LANE_W +: LANE_W];
      expOe = mV[1] && !mW[1];
      if (expOe) expOut = refMem[mA[1]];
      mV[1] = mV[0]; mW[1] = mW[0]; mA[1] = mA[0]; mM[1] = mM[0];
      if (!adv) begin
        if (!c1n && c2 && !c3n) begin
          mV[0] = 1'b1; mW[0] = !rw; mA[0] = a;
          bAct = 1'b1; bWr = !rw; bAddr = a;
        end else begin
          mV[0] = 1'b0; bAct = 1'b0;
        end
      end else if (bAct) begin
        bAddr = {bAddr[AW-1:2], bAddr[1:0] + 2'd1};
        mV[0] = 1'b1; mW[0] = bWr; mA[0] = bAddr;
      end else begin
        mV[0] = 1'b0;
      end
      mM[0] = (mV[0] && mW[0]) ? ~bwn : '0;
    end
    @(negedge clk);
    check(tag, "dOe", {{(WORD_W-1){1'b0}}, dOe}, {{(WORD_W-1){1'b0}}, expOe});
    if (expOe) check(tag, "dOut", dOut, expOut);
  endtask

  task automatic nop(input logic [WORD_W-1:0] din, input string tag);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, '0, din, tag);
  endtask
  task automatic ldw(input logic [AW-1:0] a, input logic [LANES-1:0] bwn,
                     input logic [WORD_W-1:0] din, input string tag);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, bwn, a, din, tag);
  endtask
  task automatic ldr(input logic [AW-1:0] a, input logic [WORD_W-1:0] din, input string tag);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, a, din, tag);
  endtask
  task automatic advc(input logic rw, input logic [LANES-1:0] bwn,
                      input logic [WORD_W-1:0] din, input string tag);
    // selects deliberately false: ignored while advancing
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, rw, bwn, 8'hEE, din, tag);
  endtask
  task automatic susp(input logic [WORD_W-1:0] din, input string tag);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'h21, din, tag);
  endtask

  task automatic t_reset();
    check("R8", "dOe after reset", {{(WORD_W-1){1'b0}}, dOe}, '0);
    nop('0, "R8");
  endtask

  task automatic t_fill();
    logic [AW-1:0] al [8] = '{8'h10, 8'h20, 8'h21, 8'h30, 8'h31, 8'h32, 8'h33, 8'h44};
    for (int i = 0; i < 8; i++) ldw(al[i], 4'h0, (i >= 2) ? pat(al[i-2], 8'h01) : '0, "R3");
    nop(pat(al[6], 8'h01), "R3");
    nop(pat(al[7], 8'h01), "R3");
    for (int i = 0; i < 8; i++) ldr(al[i], '0, "R2");
    nop('0, "R2"); nop('0, "R2");
  endtask

  task automatic t_interleave();
    ldw(8'h20, 4'h0, '0, "R9");
    ldr(8'h20, '0, "R9");
    ldw(8'h21, 4'h0, pat(8'h20, 8'h22), "R9");
    ldr(8'h21, '0, "R9");
    nop(pat(8'h21, 8'h23), "R9");
    nop('0, "R9"); nop('0, "R9");
  endtask

  task automatic t_bytes();
    ldw(8'h10, 4'b1010, '0, "R4");
    ldw(8'h10, 4'hF, '0, "R4");
    nop(36'h1_2345_6789, "R4");
    nop(36'hF_FFFF_FFFF, "R4");
    ldr(8'h10, '0, "R4");
    nop('0, "R4"); nop('0, "R4");
  endtask

  task automatic t_burst();
    ldw(8'h33, 4'h0, '0, "R5");
    advc(1'b1, 4'h0, '0, "R5");
    advc(1'b1, 4'b0110, pat(8'h33, 8'h50), "R5");
    advc(1'b1, 4'h0, pat(8'h30, 8'h51), "R5");
    nop(pat(8'h31, 8'h52), "R5");
    nop(pat(8'h32, 8'h53), "R5");
    ldr(8'h32, '0, "R5");
    advc(1'b0, 4'h0, '0, "R5");
    advc(1'b0, 4'h0, '0, "R5");
    advc(1'b0, 4'h0, '0, "R5");
    nop('0, "R5"); nop('0, "R5");
  endtask

  task automatic t_deselect();
    ldr(8'h10, '0, "R1");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h10, '0, "R1");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 8'h20, 36'h0_DEAD_BEEF, "R1");
    advc(1'b0, 4'h0, 36'h0_BAD0_BAD0, "R6");
    advc(1'b0, 4'h0, 36'h0_BAD1_BAD1, "R6");
    nop(36'h0_BAD2_BAD2, "R6");
    nop(36'h0_BAD3_BAD3, "R6");
    ldr(8'h10, '0, "R1"); ldr(8'h20, '0, "R1"); ldr(8'h31, '0, "R6");
    nop('0, "R6"); nop('0, "R6");
  endtask

  task automatic t_suspend();
    ldw(8'h21, 4'h0, '0, "R7");
    susp(36'h0_1111_1111, "R7");
    susp(36'h0_2222_2222, "R7");
    ldr(8'h21, '0, "R7");
    susp(36'h0_3333_3333, "R7");
    nop(pat(8'h21, 8'h77), "R7");
    susp('0, "R7");
    nop('0, "R7");
    susp('0, "R7");
    susp('0, "R7");
    nop('0, "R7"); nop('0, "R7");
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin mV[i] = 0; mW[i] = 0; mA[i] = '0; mM[i] = '0; end
    bAct = 0; bWr = 0; bAddr = '0; expOe = 0; expOut = '0;
    rst_n = 1'b0; clkEn_n = 1'b0; selA_n = 1'b1; selB = 1'b1; selC_n = 1'b0;
    burstNext = 1'b0; isRead = 1'b1; laneWrEn_n = 4'hF; addr = '0; dIn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_interleave();
    t_bytes();
    t_burst();
    t_deselect();
    t_suspend();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule